// File: doc/BRIEF.md
# Serial Video Lock and Format Detector

This block sits behind a clock-recovery PLL and a deserializer and qualifies the recovered 10-bit parallel word stream. It watches for two kinds of synchronisation patterns: the three-word video timing reference (all-ones followed by two all-zero words) and the 8b/10b comma character in either disparity. From these it decides whether the stream is locked and which format it carries. It then drives a lock flag, two format status flags and a gated copy of the parallel data. Every output is registered on the parallel word clock.

In auto mode the block classifies the stream itself and reports the format on its two status outputs. A stream that matches neither pattern is blanked. In manual mode the format is chosen through two user inputs and the data always passes through while the PLL is locked. When both user inputs are low, the block is in data-through operation and reports lock on PLL lock alone. Whenever the PLL lock input is low, detection is cleared and every output except the clock is held low. Any change of the mode inputs restarts detection.

Top module: `slq_top`

## Requirements
- R1: While `pll_lock_i` is low, no sync word is counted, both format trackers are cleared, and on the following edge `locked_o`, `smpte_flag_o`, `asi_flag_o` and `word_o` are all zero.
- R2: A video sync word is the three consecutive words 0x3FF, 0x000, 0x000 and is counted on the word that carries the second 0x000. A comma sync word is a single word equal to 0x17C or 0x283.
- R3: A format is found when FIND_COUNT of its sync words fall within FIND_WINDOW consecutive words, counted from the first of them (positions 0 to FIND_WINDOW-1). A sync word at position FIND_WINDOW opens a new window as its first word.
- R4: A found format is lost once LOSS_WORDS consecutive words carry none of its sync words. The lock output drops on the edge after the loss.
- R5: In auto mode (`auto_sel_i` high) with the video format found, `locked_o`=1, `smpte_flag_o`=1 and `asi_flag_o`=0. The video format wins if both formats are found.
- R6: In auto mode with only the comma format found, `locked_o`=1, `smpte_flag_o`=0 and `asi_flag_o`=1, and `word_o` follows `word_i` one edge later.
- R7: In auto mode with neither format found, `locked_o`, both flags and `word_o` are zero.
- R8: In manual mode (`auto_sel_i` low) with the PLL locked, `word_o` equals `word_i` of the previous edge whatever the stream, and both flag outputs are zero.
- R9: In manual mode with `man_smpte_i` and `man_asi_i` both low, `locked_o` is 1 whenever the PLL is locked.
- R10: In manual mode with one or both selects high, `locked_o` is 1 only when a selected format has been found.
- R11: A change on `auto_sel_i`, `man_smpte_i` or `man_asi_i` clears both trackers. Detection restarts from the searching state, and the lock output reflects the cleared state two edges after the change.
- R12: A synchronous active-high `rst` drives every output to zero and returns both trackers to searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock_i | input | 1 | Lock indication from the clock-recovery PLL |
| auto_sel_i | input | 1 | High selects auto mode, low selects manual mode |
| man_smpte_i | input | 1 | Manual-mode select for the video format |
| man_asi_i | input | 1 | Manual-mode select for the comma format |
| word_i | input | 10 | Recovered parallel word |
| locked_o | output | 1 | Stream lock flag |
| smpte_flag_o | output | 1 | Auto-mode status: video format detected |
| asi_flag_o | output | 1 | Auto-mode status: comma format detected |
| word_o | output | 10 | Gated parallel word |

## Verification
The hardest situation to reach is the window edge of R3: the third sync word must land exactly on the last position of the window, or one word beyond it. The bench runs the design with a small window and loss length and places comma words at hand-counted positions, so both sides of the boundary are hit. Loss (R4) and the restart on a mode change (R11) need a lock to be established first. The directed tests reach lock, then count non-sync words or toggle a manual select, and sample on the exact edge where the lock output must fall.

// File: rtl/slq_pkg.sv
package slq_pkg;

  localparam int WORD_W = 10;

  localparam logic [WORD_W-1:0] TRS_ONES  = 10'h3FF;
  localparam logic [WORD_W-1:0] TRS_ZERO  = 10'h000;
  localparam logic [WORD_W-1:0] COMMA_NEG = 10'h17C;
  localparam logic [WORD_W-1:0] COMMA_POS = 10'h283;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_SMPTE = 2'd1,
    FMT_ASI   = 2'd2
  } fmt_e;

  // comma character in either running disparity
  function automatic logic is_comma(input logic [WORD_W-1:0] w);
    return (w == COMMA_NEG) || (w == COMMA_POS);
  endfunction

  // three-word timing reference, oldest word first
  function automatic logic is_trs(input logic [WORD_W-1:0] w2,
                                  input logic [WORD_W-1:0] w1,
                                  input logic [WORD_W-1:0] w0);
    return (w2 == TRS_ONES) && (w1 == TRS_ZERO) && (w0 == TRS_ZERO);
  endfunction

  // a word at position pos still belongs to a window of win words
  function automatic logic window_open(input int unsigned pos,
                                       input int unsigned win);
    return pos < win;
  endfunction

endpackage

// File: rtl/slq_sync_match.sv
module slq_sync_match
  import slq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic              smpte_hit,
  output logic              asi_hit
);

  logic [WORD_W-1:0] hist1;
  logic [WORD_W-1:0] hist2;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1 <= '0;
      hist2 <= '0;
    end else begin
      hist1 <= word;
      hist2 <= hist1;
    end
  end

  always_comb begin
    smpte_hit = en && is_trs(hist2, hist1, word);
    asi_hit   = en && is_comma(word);
  end

endmodule

// File: rtl/slq_format_tracker.sv
module slq_format_tracker #(
  parameter int FIND_COUNT  = 3,
  parameter int FIND_WINDOW = 2048,
  parameter int LOSS_WORDS  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic hit,
  output logic found
);
  import slq_pkg::*;

  localparam int CW = $clog2(FIND_COUNT + 1);
  localparam int PW = $clog2(FIND_WINDOW + 1);
  localparam int LW = $clog2(LOSS_WORDS);
  localparam logic [CW-1:0] CNT_LAST  = CW'(FIND_COUNT - 1);
  localparam logic [LW-1:0] LOSS_LAST = LW'(LOSS_WORDS - 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pos;
  logic [LW-1:0] loss;
  logic [PW-1:0] pos_n;
  logic          in_window;

  always_comb begin
    pos_n     = pos + PW'(1);
    in_window = window_open(32'(pos_n), FIND_WINDOW);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found <= 1'b0;
      cnt   <= '0;
      pos   <= '0;
      loss  <= '0;
    end else if (found) begin
      if (hit) begin
        loss <= '0;
      end else if (loss == LOSS_LAST) begin
        found <= 1'b0;
        loss  <= '0;
        cnt   <= '0;
        pos   <= '0;
      end else begin
        loss <= loss + LW'(1);
      end
    end else if (cnt == '0) begin
      if (hit) begin
        cnt <= CW'(1);
        pos <= '0;
      end
    end else if (in_window) begin
      pos <= pos_n;
      if (hit) begin
        if (cnt == CNT_LAST) begin
          found <= 1'b1;
          cnt   <= '0;
          loss  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end else begin
      pos <= '0;
      cnt <= hit ? CW'(1) : '0;
    end
  end

endmodule

// File: rtl/slq_out_select.sv
module slq_out_select
  import slq_pkg::*;
(
  input  logic              pll_lock,
  input  logic              auto_sel,
  input  logic              man_smpte,
  input  logic              man_asi,
  input  logic              smpte_found,
  input  logic              asi_found,
  input  logic [WORD_W-1:0] word,
  output logic              locked_n,
  output logic              smpte_flag_n,
  output logic              asi_flag_n,
  output logic [WORD_W-1:0] word_n
);

  fmt_e fmt;

  always_comb begin
    if (smpte_found)    fmt = FMT_SMPTE;
    else if (asi_found) fmt = FMT_ASI;
    else                fmt = FMT_NONE;
  end

  always_comb begin
    locked_n     = 1'b0;
    smpte_flag_n = 1'b0;
    asi_flag_n   = 1'b0;
    word_n       = '0;
    if (pll_lock) begin
      if (auto_sel) begin
        locked_n     = (fmt != FMT_NONE);
        smpte_flag_n = (fmt == FMT_SMPTE);
        asi_flag_n   = (fmt == FMT_ASI);
        word_n       = (fmt != FMT_NONE) ? word : '0;
      end else begin
        locked_n = (!man_smpte && !man_asi)
                 || (man_smpte && smpte_found)
                 || (man_asi && asi_found);
        word_n   = word;
      end
    end
  end

endmodule

// File: rtl/slq_top.sv
module slq_top
  import slq_pkg::*;
#(
  parameter int FIND_COUNT  = 3,
  parameter int FIND_WINDOW = 2048,
  parameter int LOSS_WORDS  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_lock_i,
  input  logic              auto_sel_i,
  input  logic              man_smpte_i,
  input  logic              man_asi_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              locked_o,
  output logic              smpte_flag_o,
  output logic              asi_flag_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int NFMT = 2;

  logic [2:0]        mode_q;
  logic              restart;
  logic              clear;
  logic              smpte_hit;
  logic              asi_hit;
  logic              smpte_found;
  logic              asi_found;
  logic [NFMT-1:0]   hit_vec;
  logic [NFMT-1:0]   found_vec;
  logic              locked_n;
  logic              smpte_flag_n;
  logic              asi_flag_n;
  logic [WORD_W-1:0] word_n;

  // mode-input change detection
  always_ff @(posedge clk) begin
    mode_q <= {auto_sel_i, man_smpte_i, man_asi_i};
  end

  always_comb begin
    restart = !rst && (mode_q != {auto_sel_i, man_smpte_i, man_asi_i});
    clear   = restart || !pll_lock_i;
  end

  slq_sync_match u_match (
    .clk       (clk),
    .rst       (rst),
    .en        (pll_lock_i),
    .word      (word_i),
    .smpte_hit (smpte_hit),
    .asi_hit   (asi_hit)
  );

  assign hit_vec = {asi_hit, smpte_hit};

  for (genvar g = 0; g < NFMT; g++) begin : g_trk
    slq_format_tracker #(
      .FIND_COUNT  (FIND_COUNT),
      .FIND_WINDOW (FIND_WINDOW),
      .LOSS_WORDS  (LOSS_WORDS)
    ) u_trk (
      .clk   (clk),
      .rst   (rst),
      .clear (clear),
      .hit   (hit_vec[g]),
      .found (found_vec[g])
    );
  end

  assign smpte_found = found_vec[0];
  assign asi_found   = found_vec[1];

  slq_out_select u_sel (
    .pll_lock     (pll_lock_i),
    .auto_sel     (auto_sel_i),
    .man_smpte    (man_smpte_i),
    .man_asi      (man_asi_i),
    .smpte_found  (smpte_found),
    .asi_found    (asi_found),
    .word         (word_i),
    .locked_n     (locked_n),
    .smpte_flag_n (smpte_flag_n),
    .asi_flag_n   (asi_flag_n),
    .word_n       (word_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o     <= 1'b0;
      smpte_flag_o <= 1'b0;
      asi_flag_o   <= 1'b0;
      word_o       <= '0;
    end else begin
      locked_o     <= locked_n;
      smpte_flag_o <= smpte_flag_n;
      asi_flag_o   <= asi_flag_n;
      word_o       <= word_n;
    end
  end

endmodule

// File: rtl/slq_checker.sv
module slq_checker (
  input logic       clk,
  input logic       rst,
  input logic       pll_lock_i,
  input logic       auto_sel_i,
  input logic [9:0] word_i,
  input logic       locked_o,
  input logic       smpte_flag_o,
  input logic       asi_flag_o,
  input logic [9:0] word_o,
  input logic       smpte_hit,
  input logic       asi_hit,
  input logic       smpte_found,
  input logic       asi_found,
  input logic       restart
);

  // R1
  pll_low_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_lock_i |=> (!locked_o && !smpte_flag_o && !asi_flag_o && word_o == '0));

  // R1
  pll_low_no_search_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_lock_i |-> (!smpte_hit && !asi_hit));

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smpte_flag_o, asi_flag_o}));

  // R6
  flag_implies_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (smpte_flag_o || asi_flag_o) |-> locked_o);

  // R7
  auto_unfound_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (pll_lock_i && auto_sel_i && !smpte_found && !asi_found)
      |=> (!locked_o && word_o == '0));

  // R8
  manual_flags_low_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_sel_i |=> (!smpte_flag_o && !asi_flag_o));

  // R8
  manual_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pll_lock_i && !auto_sel_i) |=> (word_o == $past(word_i)));

  // R3
  comma_found_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asi_found) |-> $past(asi_hit));

  // R3
  trs_found_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(smpte_found) |-> $past(smpte_hit));

  // R11
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!smpte_found && !asi_found));

endmodule

bind slq_top slq_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .pll_lock_i   (pll_lock_i),
  .auto_sel_i   (auto_sel_i),
  .word_i       (word_i),
  .locked_o     (locked_o),
  .smpte_flag_o (smpte_flag_o),
  .asi_flag_o   (asi_flag_o),
  .word_o       (word_o),
  .smpte_hit    (smpte_hit),
  .asi_hit      (asi_hit),
  .smpte_found  (smpte_found),
  .asi_found    (asi_found),
  .restart      (restart)
);

// File: tb/sim_slq_top.sv
`timescale 1ns/1ps
module sim_slq_top;

  localparam int FC = 3;
  localparam int FW = 16;
  localparam int LW = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pll_lock_i = 1'b0;
  logic       auto_sel_i = 1'b0;
  logic       man_smpte_i = 1'b0;
  logic       man_asi_i = 1'b0;
  logic [9:0] word_i = '0;
  logic       locked_o;
  logic       smpte_flag_o;
  logic       asi_flag_o;
  logic [9:0] word_o;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  slq_top #(.FIND_COUNT(FC), .FIND_WINDOW(FW), .LOSS_WORDS(LW)) u0 (
    .clk(clk), .rst(rst), .pll_lock_i(pll_lock_i), .auto_sel_i(auto_sel_i),
    .man_smpte_i(man_smpte_i), .man_asi_i(man_asi_i), .word_i(word_i),
    .locked_o(locked_o), .smpte_flag_o(smpte_flag_o), .asi_flag_o(asi_flag_o),
    .word_o(word_o)
  );

  // {auto, man_smpte, man_asi, kind[1:0], exp_locked, exp_smpte, exp_asi, exp_pass}
  // kind: 0 comma stream, 1 timing-reference stream, 2 neither
  localparam logic [8:0] VEC [0:8] = '{
    9'b1_0_0_00_1_0_1_1,
    9'b1_0_0_01_1_1_0_1,
    9'b1_0_0_10_0_0_0_0,
    9'b0_0_0_10_1_0_0_1,
    9'b0_1_0_10_0_0_0_1,
    9'b0_1_0_01_1_0_0_1,
    9'b0_0_1_00_1_0_0_1,
    9'b0_0_1_10_0_0_0_1,
    9'b0_1_1_00_1_0_0_1
  };

  function automatic logic [9:0] filler(input int i);
    return 10'h040 + 10'(i % 32);
  endfunction

  function automatic logic [9:0] stream_word(input logic [1:0] kind, input int i);
    case (kind)
      2'd0: return (i % 4 == 0) ? ((i % 8 == 0) ? 10'h17C : 10'h283) : filler(i);
      2'd1: begin
        if (i % 5 == 0)      return 10'h3FF;
        else if (i % 5 <= 2) return 10'h000;
        else                 return filler(i);
      end
      default: return filler(i);
    endcase
  endfunction

  task automatic tick(input logic [9:0] w);
    word_i = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) tick(filler(i));
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic a, input logic ms, input logic ma);
    @(negedge clk);
    rst = 1'b1;
    pll_lock_i = 1'b1;
    auto_sel_i = a;
    man_smpte_i = ms;
    man_asi_i = ma;
    tick(10'h050);
    tick(10'h051);
    rst = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #500000;
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    // R12: reset state
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R12 locked", 32'(locked_o), 0);
    chk("R12 flags", 32'({smpte_flag_o, asi_flag_o}), 0);
    chk("R12 word", 32'(word_o), 0);

    // table: R2, R5, R6, R7, R8, R9, R10
    for (int k = 0; k < 9; k++) begin
      logic [8:0] v;
      v = VEC[k];
      do_reset(v[8], v[7], v[6]);
      for (int i = 0; i < 30; i++) tick(stream_word(v[5:4], i));
      tick(10'h2AA);
      chk(v[8] ? "R5/R6/R7 locked" : "R9/R10 locked", 32'(locked_o), 32'(v[3]));
      chk(v[8] ? "R5/R6/R7 video flag" : "R8 video flag", 32'(smpte_flag_o), 32'(v[2]));
      chk(v[8] ? "R5/R6/R7 comma flag" : "R8 comma flag", 32'(asi_flag_o), 32'(v[1]));
      chk(v[8] ? "R6/R7 word" : "R8 word", 32'(word_o), v[0] ? 32'h2AA : 32'h0);
    end

    // R3: third sync word on the last window position
    do_reset(1'b1, 1'b0, 1'b0);
    tick(10'h17C); fill(6);
    tick(10'h283); fill(7);
    tick(10'h17C);
    tick(10'h045);
    chk("R3 last position locks", 32'(locked_o), 1);
    chk("R6 comma flag", 32'(asi_flag_o), 1);

    // R4: loss after LW non-sync words (one filler already given)
    fill(LW - 1);
    chk("R4 still locked at loss edge", 32'(locked_o), 1);
    tick(10'h046);
    chk("R4 lock dropped", 32'(locked_o), 0);
    chk("R4/R7 word blanked", 32'(word_o), 0);

    // R3: third sync word one past the window
    do_reset(1'b1, 1'b0, 1'b0);
    tick(10'h17C); fill(6);
    tick(10'h283); fill(8);
    tick(10'h17C);
    tick(10'h045);
    chk("R3 outside window no lock", 32'(locked_o), 0);
    fill(3);
    tick(10'h283);
    tick(10'h045);
    chk("R3 new window two words no lock", 32'(locked_o), 0);
    tick(10'h17C);
    tick(10'h045);
    chk("R3 new window locks", 32'(locked_o), 1);

    // R1: PLL low blanks and clears detection
    pll_lock_i = 1'b0;
    tick(10'h17C);
    chk("R1 locked low", 32'(locked_o), 0);
    chk("R1 word low", 32'(word_o), 0);
    chk("R1 flags low", 32'({smpte_flag_o, asi_flag_o}), 0);
    pll_lock_i = 1'b1;
    tick(10'h045);
    chk("R1 detection cleared", 32'(locked_o), 0);

    // R11: manual select change restarts detection
    do_reset(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) tick(stream_word(2'd0, i));
    tick(10'h045);
    chk("R10 comma selected locked", 32'(locked_o), 1);
    man_smpte_i = 1'b1;
    tick(10'h046);
    tick(10'h047);
    chk("R11 restart drops lock", 32'(locked_o), 0);
    chk("R8 pass after restart", 32'(word_o), 32'h047);
    for (int i = 0; i < 12; i++) tick(stream_word(2'd0, i));
    tick(10'h045);
    chk("R11 relock after restart", 32'(locked_o), 1);

    finish_run();
  end

endmodule